// File: doc/BRIEF.md
# SONET/SDH Frame Aligner

This block takes a byte-aligned SONET/SDH line stream, with one byte per valid strobe, and finds where each frame begins. A frame begins with a run of A1 bytes followed by a run of A2 bytes. A four-state machine controls alignment. It starts in a hunt state and looks for the header at every byte offset. It then confirms the header over several frames, and declares lock once the header has been seen in every one of them. After lock, a coast (flywheel) state rides out short bursts of missed headers before the machine gives up and goes back to hunting.

While the block is aligned, each incoming byte appears on the output one clock later. A one-cycle start-of-frame flag marks the first A1 byte of each frame. When framing is switched off, the stream passes through unchanged and the machine stays in hunt. A saturating counter records how many times lock has been lost, and a clear strobe resets it.

Top module: `sdh_frame_aligner`

## Requirements
- R1: After reset, `align_state` is 0, `out_vld` and `out_sof` are 0, and `lof_count` is 0.
- R2: The state codes are 0 Search, 1 Check, 2 Lock and 3 Flywheel. The header is 0xF6, 0xF6, 0xF6, 0x28, 0x28, 0x28. In Search, a complete header ending on any valid byte moves the machine to Check. That last header byte is frame position 5, and frame position 0 is the first 0xF6.
- R3: In Check, the machine moves to Lock once the header has ended at position 5 in three consecutive frames that follow the acquiring frame. One frame is `FRAME_BYTES` valid bytes (default 810 × `STS_LEVEL`).
- R4: In Check, any frame whose position 5 does not complete a header sends the machine back to Search.
- R5: In Lock, a frame with a good header keeps the machine in Lock, and a frame with a missed header moves it to Flywheel.
- R6: In Flywheel, a good header returns the machine to Lock. Three consecutive missed headers while in Flywheel return it to Search.
- R7: While framing is enabled, a byte accepted in Lock or Flywheel appears on `out_byte` with `out_vld` high one cycle later, with the same value. A byte accepted in Search or Check is not forwarded. The header bytes of a frame are handled in the state held before that frame's header is checked, and the rest of the frame in the state after the check.
- R8: `out_sof` is high for exactly the one output cycle that carries the position-0 byte of a frame accepted in Lock or Flywheel.
- R9: While `frm_en` is low, every valid input byte is forwarded one cycle later, `out_sof` stays low, and the machine is held in Search.
- R10: `lof_count` increments by one on each change from Lock to Flywheel and saturates at its all-ones value. A one-cycle `lof_clr` pulse sets it to 0, and the clear wins over a simultaneous increment.
- R11: Cycles with `in_vld` low neither advance the frame position nor change the state, so idle gaps inside a frame do not disturb alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_byte | input | 8 | Incoming line byte |
| in_vld | input | 1 | `in_byte` holds a valid byte this cycle |
| frm_en | input | 1 | Framing enable; when low, bytes pass through unframed |
| lof_clr | input | 1 | Clears the loss-of-frame counter |
| out_byte | output | 8 | Forwarded byte |
| out_vld | output | 1 | `out_byte` is valid |
| out_sof | output | 1 | Start-of-frame flag on the position-0 byte |
| align_state | output | 2 | Current alignment state (0 Search, 1 Check, 2 Lock, 3 Flywheel) |
| lof_count | output | LOF_W | Saturating count of Lock-to-Flywheel changes |

## Verification
The assertions assume the input stream is already byte-aligned. They also assume that filler bytes never reproduce the header by chance, so the only header hits are the ones placed at frame position 0.

The stimulus draws random filler with `$urandom` and replaces any 0xF6 byte with 0x00, so no false header can form. Idle cycles are inserted at random between valid bytes. The stimulus changes `frm_en` and `lof_clr` only on the falling clock edge, and only between whole frames. The bench narrows the counter width so that saturation can be reached in a few frames.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

   typedef enum logic [1:0] {
      SFA_SEARCH = 2'd0,
      SFA_CHECK  = 2'd1,
      SFA_LOCK   = 2'd2,
      SFA_FLY    = 2'd3
   } sfa_state_e;

   localparam logic [7:0] SFA_A1_DEFAULT = 8'hF6;
   localparam logic [7:0] SFA_A2_DEFAULT = 8'h28;

endpackage

// File: rtl/sfa_hdr_match.sv
module sfa_hdr_match #(
   parameter int         A1_N    = 3,
   parameter int         A2_N    = 3,
   parameter logic [7:0] A1_BYTE = 8'hF6,
   parameter logic [7:0] A2_BYTE = 8'h28
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] byte_i,
   input  logic       vld_i,
   output logic       hit_o
);
   localparam int HLEN = A1_N + A2_N;

   if (A1_N < 1 || A2_N < 1 || HLEN < 3) begin : g_bad_hdr
      $error("sfa_hdr_match: header needs at least one A1, one A2 and three bytes");
   end

   // hist_q[0] holds the most recent accepted byte
   logic [HLEN-2:0][7:0] hist_q;
   logic [HLEN-1:0]      eq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else if (vld_i) begin
         hist_q <= {hist_q[HLEN-3:0], byte_i};
      end
   end

   // window slot 0 is the oldest byte (first A1), slot HLEN-1 the incoming byte
   for (genvar i = 0; i < HLEN; i++) begin : g_slot
      localparam logic [7:0] EXP = (i < A1_N) ? A1_BYTE : A2_BYTE;
      if (i == HLEN - 1) begin : g_live
         assign eq[i] = (byte_i == EXP);
      end else begin : g_hist
         assign eq[i] = (hist_q[HLEN-2-i] == EXP);
      end
   end

   assign hit_o = vld_i & (&eq);

endmodule

// File: rtl/sfa_pos_ctr.sv
module sfa_pos_ctr #(
   parameter int FRAME_BYTES = 810,
   parameter int LOAD_POS    = 6,
   localparam int PW         = $clog2(FRAME_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          adv_i,
   output logic [PW-1:0] pos_o
);
   localparam logic [PW-1:0] LAST = PW'(FRAME_BYTES - 1);
   localparam logic [PW-1:0] LDV  = PW'(LOAD_POS % FRAME_BYTES);

   if (FRAME_BYTES < 2) begin : g_bad_len
      $error("sfa_pos_ctr: frame must be at least two bytes");
   end

   logic [PW-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (load_i) begin
         pos_q <= LDV;
      end else if (adv_i) begin
         pos_q <= (pos_q == LAST) ? '0 : pos_q + PW'(1);
      end
   end

   assign pos_o = pos_q;

endmodule

// File: rtl/sfa_sat_ctr.sv
module sfa_sat_ctr #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   input  logic         clr_i,
   output logic [W-1:0] cnt_o
);
   if (W < 1) begin : g_bad_w
      $error("sfa_sat_ctr: width must be positive");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i && !(&cnt_q)) begin
         cnt_q <= cnt_q + W'(1);
      end
   end

   assign cnt_o = cnt_q;

   AST_LOF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> cnt_o == '0); // R10
   AST_LOF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + W'(1))); // R10
   AST_LOF_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && (&cnt_o)) |=> (&cnt_o)); // R10

endmodule

// File: rtl/sdh_frame_aligner.sv
module sdh_frame_aligner
   import sfa_pkg::*;
#(
   parameter int         STS_LEVEL      = 1,
   parameter int         FRAME_BYTES    = 810 * STS_LEVEL,
   parameter int         A1_COUNT       = 3,
   parameter int         A2_COUNT       = 3,
   parameter logic [7:0] A1_PATTERN     = SFA_A1_DEFAULT,
   parameter logic [7:0] A2_PATTERN     = SFA_A2_DEFAULT,
   parameter int         CONFIRM_FRAMES = 3,
   parameter int         MISS_FRAMES    = 3,
   parameter int         LOF_W          = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       in_byte,
   input  logic             in_vld,
   input  logic             frm_en,
   input  logic             lof_clr,
   output logic [7:0]       out_byte,
   output logic             out_vld,
   output logic             out_sof,
   output logic [1:0]       align_state,
   output logic [LOF_W-1:0] lof_count
);
   localparam int HLEN    = A1_COUNT + A2_COUNT;
   localparam int PW      = $clog2(FRAME_BYTES);
   localparam int GW      = $clog2(CONFIRM_FRAMES + 1);
   localparam int MW      = $clog2(MISS_FRAMES + 1);
   localparam int CHK_POS = HLEN - 1;

   if (FRAME_BYTES < 2 * HLEN) begin : g_bad_frame
      $error("sdh_frame_aligner: frame shorter than twice the header");
   end
   if (CONFIRM_FRAMES < 1 || MISS_FRAMES < 1) begin : g_bad_hyst
      $error("sdh_frame_aligner: hysteresis counts must be positive");
   end

   sfa_state_e    st_q, st_d;
   logic [GW-1:0] good_q, good_d;
   logic [MW-1:0] miss_q, miss_d;
   logic          hdr_hit;
   logic [PW-1:0] pos;
   logic          at_chk, in_frame, lof_inc;
   logic          fwd, sof_d;

   sfa_hdr_match #(
      .A1_N    (A1_COUNT),
      .A2_N    (A2_COUNT),
      .A1_BYTE (A1_PATTERN),
      .A2_BYTE (A2_PATTERN)
   ) u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .byte_i (in_byte),
      .vld_i  (in_vld),
      .hit_o  (hdr_hit)
   );

   sfa_pos_ctr #(
      .FRAME_BYTES (FRAME_BYTES),
      .LOAD_POS    (HLEN)
   ) u_pos (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (frm_en && st_q == SFA_SEARCH && hdr_hit),
      .adv_i  (frm_en && in_vld && st_q != SFA_SEARCH),
      .pos_o  (pos)
   );

   sfa_sat_ctr #(
      .W (LOF_W)
   ) u_lof (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (lof_inc),
      .clr_i (lof_clr),
      .cnt_o (lof_count)
   );

   assign at_chk   = in_vld && (pos == PW'(CHK_POS));
   assign in_frame = (st_q == SFA_LOCK) || (st_q == SFA_FLY);

   always_comb begin
      st_d    = st_q;
      good_d  = good_q;
      miss_d  = miss_q;
      lof_inc = 1'b0;
      if (!frm_en) begin
         st_d   = SFA_SEARCH;
         good_d = '0;
         miss_d = '0;
      end else if (in_vld) begin
         unique case (st_q)
            SFA_SEARCH: begin
               if (hdr_hit) begin
                  st_d   = SFA_CHECK;
                  good_d = '0;
               end
            end
            SFA_CHECK: begin
               if (at_chk) begin
                  if (!hdr_hit) begin
                     st_d   = SFA_SEARCH;
                     good_d = '0;
                  end else if (good_q == GW'(CONFIRM_FRAMES - 1)) begin
                     st_d   = SFA_LOCK;
                     good_d = '0;
                  end else begin
                     good_d = good_q + GW'(1);
                  end
               end
            end
            SFA_LOCK: begin
               if (at_chk && !hdr_hit) begin
                  st_d    = SFA_FLY;
                  miss_d  = '0;
                  lof_inc = 1'b1;
               end
            end
            SFA_FLY: begin
               if (at_chk) begin
                  if (hdr_hit) begin
                     st_d   = SFA_LOCK;
                     miss_d = '0;
                  end else if (miss_q == MW'(MISS_FRAMES - 1)) begin
                     st_d   = SFA_SEARCH;
                     miss_d = '0;
                  end else begin
                     miss_d = miss_q + MW'(1);
                  end
               end
            end
            default: st_d = SFA_SEARCH;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SFA_SEARCH;
         good_q <= '0;
         miss_q <= '0;
      end else begin
         st_q   <= st_d;
         good_q <= good_d;
         miss_q <= miss_d;
      end
   end

   assign fwd   = in_vld && (!frm_en || in_frame);
   assign sof_d = frm_en && in_vld && in_frame && (pos == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_byte <= '0;
         out_vld  <= 1'b0;
         out_sof  <= 1'b0;
      end else begin
         out_vld <= fwd;
         out_sof <= sof_d;
         if (fwd) begin
            out_byte <= in_byte;
         end
      end
   end

   assign align_state = st_q;

   AST_CHECK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SFA_CHECK && $past(st_q) != SFA_CHECK) |-> $past(st_q) == SFA_SEARCH); // R2
   AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SFA_LOCK && $past(st_q) != SFA_LOCK)
         |-> ($past(st_q) == SFA_CHECK || $past(st_q) == SFA_FLY)); // R3
   AST_FLY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SFA_FLY && $past(st_q) != SFA_FLY) |-> $past(st_q) == SFA_LOCK); // R5
   AST_NO_FWD_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_en && (st_q == SFA_SEARCH || st_q == SFA_CHECK)) |=> !out_vld); // R7
   AST_FWD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_en && in_vld && in_frame) |=> (out_vld && out_byte == $past(in_byte))); // R7
   AST_SOF_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_vld); // R8
   AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_en |=> (out_vld == $past(in_vld) && !out_sof && st_q == SFA_SEARCH)); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_en && !in_vld) |=> st_q == $past(st_q)); // R11

endmodule

// File: tb/sdh_frame_aligner_tb.sv
module sdh_frame_aligner_tb_top;
   localparam int FB = 810;
   localparam int LW = 3;
   localparam int LOF_MAX = (1 << LW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    in_byte = '0;
   logic          in_vld = 1'b0;
   logic          frm_en = 1'b1;
   logic          lof_clr = 1'b0;
   logic [7:0]    out_byte;
   logic          out_vld;
   logic          out_sof;
   logic [1:0]    align_state;
   logic [LW-1:0] lof_count;

   int     total = 0;
   int     bad = 0;
   int     obs_cnt = 0;
   int     obs_sof = 0;
   longint obs_sum = 0;
   int     m_st = 0;
   int     m_good = 0;
   int     m_miss = 0;
   int     m_lof = 0;

   always #5 clk = ~clk;

   sdh_frame_aligner #(.LOF_W(LW)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_byte     (in_byte),
      .in_vld      (in_vld),
      .frm_en      (frm_en),
      .lof_clr     (lof_clr),
      .out_byte    (out_byte),
      .out_vld     (out_vld),
      .out_sof     (out_sof),
      .align_state (align_state),
      .lof_count   (lof_count)
   );

   always @(negedge clk) begin
      if (rst_n && out_vld) begin
         obs_cnt <= obs_cnt + 1;
         obs_sum <= obs_sum + longint'(out_byte);
      end
      if (rst_n && out_sof) obs_sof <= obs_sof + 1;
   end

   task automatic check(input string tag, input longint act, input longint exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] filler();
      logic [7:0] b = 8'($urandom);
      return (b == 8'hF6) ? 8'h00 : b;
   endfunction

   // state codes: 0 Search, 1 Check, 2 Lock, 3 Flywheel
   function automatic void model_step(input bit hit);
      case (m_st)
         0: if (hit) begin m_st = 1; m_good = 0; end
         1: if (!hit) begin m_st = 0; m_good = 0; end
            else if (m_good == 2) m_st = 2;
            else m_good++;
         2: if (!hit) begin
               m_st = 3; m_miss = 0;
               if (m_lof < LOF_MAX) m_lof++;
            end
         default: if (hit) m_st = 2;
            else if (m_miss == 2) begin m_st = 0; m_miss = 0; end
            else m_miss++;
      endcase
   endfunction

   task automatic drive_byte(input logic [7:0] b, input int gap_pct);
      while (int'($urandom_range(99)) < gap_pct) begin
         @(negedge clk);
         in_vld = 1'b0;
      end
      @(negedge clk);
      in_vld  = 1'b1;
      in_byte = b;
   endtask

   task automatic settle();
      @(negedge clk);
      in_vld = 1'b0;
      @(negedge clk);
      #1;
   endtask

   task automatic send_frame(input bit ok, input int gap, input string tag);
      int     c0 = obs_cnt;
      int     f0 = obs_sof;
      longint s0 = obs_sum;
      int     ecnt = 0;
      int     esof = 0;
      longint esum = 0;
      int     st_b = m_st;
      int     st_a;
      bit     en = frm_en;
      if (en) model_step(ok);
      st_a = m_st;
      for (int p = 0; p < FB; p++) begin
         logic [7:0] b;
         bit fw;
         if (p < 3) b = ok ? 8'hF6 : 8'h11;
         else if (p < 6) b = 8'h28;
         else b = filler();
         fw = !en || (((p < 6) ? st_b : st_a) >= 2);
         if (fw) begin ecnt++; esum += longint'(b); end
         if (en && p == 0 && st_b >= 2) esof++;
         drive_byte(b, gap);
      end
      settle();
      check(tag, longint'(align_state), longint'(st_a));
      check("R7 fwd count", longint'(obs_cnt - c0), longint'(ecnt));
      check("R7 fwd sum", obs_sum - s0, esum);
      check("R8 sof", longint'(obs_sof - f0), longint'(esof));
      check("R10 lof", longint'(lof_count), longint'(m_lof));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int c0;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      #1;
      check("R1 state", longint'(align_state), 0);
      check("R1 out_vld", longint'(out_vld), 0);
      check("R1 out_sof", longint'(out_sof), 0);
      check("R1 lof", longint'(lof_count), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // junk prefix of odd length: no header, nothing forwarded
      c0 = obs_cnt;
      for (int i = 0; i < 37; i++) drive_byte(filler(), 10);
      settle();
      check("R2 stays search", longint'(align_state), 0);
      check("R7 no fwd in search", longint'(obs_cnt - c0), 0);

      // acquisition
      send_frame(1, 10, "R2 acquire");
      send_frame(1, 10, "R3 confirm1");
      send_frame(1, 10, "R3 confirm2");
      send_frame(1, 10, "R3 lock");
      send_frame(1, 10, "R5 hold lock");
      send_frame(0, 10, "R5 to flywheel");
      send_frame(1, 10, "R6 back to lock");
      send_frame(0, 10, "R5 to flywheel");
      send_frame(0, 10, "R6 fly miss1");
      send_frame(0, 10, "R6 fly miss2");
      send_frame(0, 10, "R6 to search");

      // miss during Check
      send_frame(1, 10, "R2 reacquire");
      send_frame(1, 10, "R3 confirm1");
      send_frame(0, 10, "R4 check miss");
      send_frame(1, 10, "R2 reacquire");
      for (int i = 0; i < 3; i++) send_frame(1, 10, "R3 lock again");

      // saturation of the loss counter
      for (int i = 0; i < 8; i++) begin
         send_frame(0, 5, "R5 sat miss");
         send_frame(1, 5, "R6 sat recover");
      end
      check("R10 saturated", longint'(lof_count), LOF_MAX);
      @(negedge clk);
      lof_clr = 1'b1;
      @(negedge clk);
      lof_clr = 1'b0;
      #1;
      check("R10 clear", longint'(lof_count), 0);
      m_lof = 0;

      // framing disabled: pass-through
      @(negedge clk);
      frm_en = 1'b0;
      m_st = 0; m_good = 0; m_miss = 0;
      send_frame(1, 15, "R9 disabled");
      send_frame(0, 15, "R9 disabled");
      @(negedge clk);
      frm_en = 1'b1;

      // constrained random with idle gaps
      for (int i = 0; i < 20; i++) begin
         bit ok = (int'($urandom_range(99)) < 75);
         send_frame(ok, 30, "R11 random gaps");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule